// File: doc/BRIEF.md
# Dual-Bank Multiply-Accumulate Unit

This block is a 16x16 multiplier with a 48-bit accumulator, sitting on a small register bus next to a microcontroller core. Software loads the two operand registers and the operation runs by itself. The product is either folded into the accumulator or only reported, and a 32-bit read-only result pair carries the outcome. The accumulator is held as three 16-bit words that software can read and write.

A 3-bit operation code picks one of four operations: multiply, accumulate, negate or subtract. Its top bit turns accumulator write-back off. A mode bit picks signed or unsigned arithmetic, and a second mode bit lets a single write of operand B start the operation on its own. Accumulate and subtract report whether the true result fits in 48 bits. The block holds two complete register banks, and the select input routes every access to one of them. An interrupt handler can therefore switch to the spare bank without saving the other bank's contents.

The arithmetic takes one cycle after the starting write. When write-back is on, the visible accumulator lags by one further cycle. In that case an accumulate or subtract also puts its result one cycle later. That result is the low 32 bits of the old accumulator plus or minus twice the product. Operations can start on consecutive cycles.

Top module: `mac_unit`

## Requirements
- R1: After reset, every register of both banks reads zero, including the control word and its overflow bit.
- R2: Address map: 0 control, 1 operand A, 2 operand B, 3/4/5 accumulator bits 15:0/31:16/47:32, 6/7 result bits 15:0/31:16. Control bits: [2:0] operation code, [3] unsigned mode (0 = signed), [4] single-operand mode, [7] overflow (read-only). In two-operand mode, an operation starts when operand A and operand B have both been written since the last start, in either order. Writing only one of them starts nothing. In single-operand mode, a write to operand B starts the operation using the operand A already held.
- R3: The overflow bit is updated only by codes 001 and 011. It is set when the exact result of accumulator plus or minus the product falls outside the 48-bit signed range, or outside the unsigned range when unsigned mode is on. Every other code leaves it unchanged.
- R4: Codes 000, 001, 010 and 011 load the accumulator with the product, the accumulator plus the product, the negated product, and the accumulator minus the product. The product is signed or unsigned according to the mode bit. Negate is used in signed mode only.
- R5: Codes 100 to 111 leave the accumulator unchanged. The result pair gets the low 32 bits of the product, the accumulator plus the product, the negated product, or the accumulator minus the product.
- R6: For codes 000, 010 and 100 to 111, the result pair shows the new value in the cycle after the starting write.
- R7: For codes 001 and 011, the result pair gets the low 32 bits of the old accumulator plus or minus twice the product. It shows the new value two cycles after the starting write and still reads its previous value in the cycle before that.
- R8: With write-back on, the accumulator words read their old value in the cycle after the starting write and the new value one cycle later.
- R9: Operand writes that start operations on consecutive cycles are all carried out in order, and each one uses the accumulator left by the previous one.
- R10: The two banks are independent. Activity in the bank that is not selected leaves the other bank's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 1 | Selects the bank used for writes and reads |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Write address |
| wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rdata | output | 16 | Read data of the selected bank, combinational |

## Verification
The assertions assume that software does not write an accumulator word in the two cycles after it starts an operation in the same bank. They also assume that the negate code is used only in signed mode. The random stimulus always waits at least two cycles after a starting write before it touches the accumulator again, and it forces signed mode whenever it picks code 010. The only operations started on consecutive cycles come from the directed operand-B burst, and that burst contains no accumulator writes.

// File: rtl/mac_pkg.sv
package mac_pkg;
    parameter int unsigned DW    = 16;
    parameter int unsigned RES_W = 2 * DW;
    parameter int unsigned AW    = 3 * DW;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_OPA  = 3'd1;
    localparam logic [2:0] A_OPB  = 3'd2;
    localparam logic [2:0] A_ACC0 = 3'd3;
    localparam logic [2:0] A_ACC1 = 3'd4;
    localparam logic [2:0] A_ACC2 = 3'd5;
    localparam logic [2:0] A_RES0 = 3'd6;
    localparam logic [2:0] A_RES1 = 3'd7;

    localparam int unsigned B_ACC  = 0;   // add accumulator
    localparam int unsigned B_SUB  = 1;   // subtract / negate
    localparam int unsigned B_NOWB = 2;   // no accumulator write-back
    localparam int unsigned B_UNS  = 3;
    localparam int unsigned B_ONE  = 4;
    localparam int unsigned B_OVF  = 7;

    typedef struct packed {
        logic [DW-1:0]    opa;
        logic [DW-1:0]    opb;
        logic [2:0]       op;
        logic             uns;
        logic             one;
        logic             ovf;
        logic [AW-1:0]    acc;
        logic [AW-1:0]    vis;
        logic [RES_W-1:0] res;
        logic             a_seen;
        logic             b_seen;
        logic             ex;
        logic [2:0]       ex_op;
        logic             ex_uns;
        logic             s2;
        logic             s2_sub;
        logic [RES_W-1:0] s2_p;
    } bank_t;
endpackage

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          uns,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] acc,
    output logic [AW-1:0] prod,
    output logic [AW-1:0] nxt,
    output logic          ovf
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] p_raw;
    logic [AW:0]   e_acc;
    logic [AW:0]   e_p;
    logic [AW:0]   sum;
    logic [AW:0]   dif;

    always_comb begin
        if (uns)
            p_raw = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        else
            p_raw = {{DW{a[DW-1]}}, a} * {{DW{b[DW-1]}}, b};
        prod  = {{(AW-PW){p_raw[PW-1] & ~uns}}, p_raw};
        e_acc = {acc[AW-1] & ~uns, acc};
        e_p   = {prod[AW-1] & ~uns, prod};
        sum   = e_acc + e_p;
        dif   = e_acc - e_p;
        case (mode)
            2'b00:   nxt = prod;
            2'b01:   nxt = sum[AW-1:0];
            2'b10:   nxt = -prod;
            default: nxt = dif[AW-1:0];
        endcase
        if (mode[B_SUB])
            ovf = uns ? dif[AW] : (dif[AW] ^ dif[AW-1]);
        else
            ovf = uns ? sum[AW] : (sum[AW] ^ sum[AW-1]);
    end
endmodule

// File: rtl/mac_bank.sv
module mac_bank
    import mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rdata
);
    bank_t q, d;

    logic [AW-1:0]    alu_prod;
    logic [AW-1:0]    alu_nxt;
    logic             alu_ovf;
    logic [RES_W-1:0] s2_sum;
    logic             acc_wr;
    logic             fire;

    mac_alu u_alu (
        .a    (q.opa),
        .b    (q.opb),
        .uns  (q.ex_uns),
        .mode (q.ex_op[1:0]),
        .acc  (q.acc),
        .prod (alu_prod),
        .nxt  (alu_nxt),
        .ovf  (alu_ovf)
    );

    always_comb begin
        d      = q;
        s2_sum = q.s2_sub ? (q.acc[RES_W-1:0] - q.s2_p) : (q.acc[RES_W-1:0] + q.s2_p);
        acc_wr = wr_en && (addr == A_ACC0 || addr == A_ACC1 || addr == A_ACC2);
        fire   = wr_en && ((addr == A_OPB && (q.one || q.a_seen)) ||
                           (addr == A_OPA && !q.one && q.b_seen));

        // second step: accumulate/subtract with write-back
        d.s2 = 1'b0;
        if (q.s2)
            d.res = s2_sum;

        // first step: arithmetic
        d.ex  = 1'b0;
        d.vis = q.acc;
        if (q.ex) begin
            if (!q.ex_op[B_NOWB]) begin
                d.acc = alu_nxt;
                if (q.ex_op[B_ACC]) begin
                    d.s2     = 1'b1;
                    d.s2_sub = q.ex_op[B_SUB];
                    d.s2_p   = alu_prod[RES_W-1:0];
                    d.ovf    = alu_ovf;
                end else begin
                    d.res = alu_nxt[RES_W-1:0];
                end
            end else begin
                d.res = alu_nxt[RES_W-1:0];
            end
        end

        // bus writes
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    d.op  = wdata[2:0];
                    d.uns = wdata[B_UNS];
                    d.one = wdata[B_ONE];
                end
                A_OPA: begin
                    d.opa    = wdata;
                    d.a_seen = 1'b1;
                end
                A_OPB: begin
                    d.opb    = wdata;
                    d.b_seen = 1'b1;
                end
                A_ACC0:  d.acc[DW-1:0]      = wdata;
                A_ACC1:  d.acc[2*DW-1:DW]   = wdata;
                A_ACC2:  d.acc[AW-1:2*DW]   = wdata;
                default: ;
            endcase
        end
        if (acc_wr)
            d.vis = d.acc;

        if (fire) begin
            d.ex     = 1'b1;
            d.ex_op  = q.op;
            d.ex_uns = q.uns;
            d.a_seen = 1'b0;
            d.b_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            A_CTRL: begin
                rdata[2:0]   = q.op;
                rdata[B_UNS] = q.uns;
                rdata[B_ONE] = q.one;
                rdata[B_OVF] = q.ovf;
            end
            A_OPA:   rdata = q.opa;
            A_OPB:   rdata = q.opb;
            A_ACC0:  rdata = q.vis[DW-1:0];
            A_ACC1:  rdata = q.vis[2*DW-1:DW];
            A_ACC2:  rdata = q.vis[AW-1:2*DW];
            A_RES0:  rdata = q.res[DW-1:0];
            default: rdata = q.res[RES_W-1:DW];
        endcase
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned NBANK = 2,
    localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bank_sel,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [DW-1:0]    wdata,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] bank_rd [NBANK];

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        mac_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (bank_sel == SEL_W'(i))),
            .addr    (addr),
            .wdata   (wdata),
            .rd_addr (rd_addr),
            .rdata   (bank_rd[i])
        );
    end

    assign rdata = bank_rd[bank_sel];
endmodule

// File: rtl/mac_chk.sv
module mac_chk
    import mac_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ex,
    input logic [2:0]       ex_op,
    input logic             s2,
    input logic             ovf,
    input logic             acc_wr,
    input logic [AW-1:0]    acc,
    input logic [AW-1:0]    vis,
    input logic [RES_W-1:0] res
);
    // R8: the visible accumulator trails the working one by a cycle
    p_acc_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> vis == $past(acc));

    // R5: no write-back leaves the accumulator alone
    p_nowb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex && ex_op[2] && !acc_wr) |=> $stable(acc));

    // R3: only codes 001 and 011 touch the overflow bit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex && (ex_op == 3'b001 || ex_op == 3'b011)) |=> $stable(ovf));

    // R7: result pair only changes when a step is in flight
    p_res_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex && !s2) |=> $stable(res));

    // R7: accumulate/subtract with write-back takes the extra step
    p_extra_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex && (ex_op == 3'b001 || ex_op == 3'b011)) |=> s2);
endmodule

bind mac_bank mac_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ex     (q.ex),
    .ex_op  (q.ex_op),
    .s2     (q.s2),
    .ovf    (q.ovf),
    .acc_wr (acc_wr),
    .acc    (q.acc),
    .vis    (q.vis),
    .res    (q.res)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [0:0]  bank_sel = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [2:0]  rd_addr = 0;
    logic [15:0] rdata;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    mac_unit u0 (.clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en),
                 .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rdata(rdata));

    always #5 clk = ~clk;

    // model
    logic [15:0] m_a [2], m_b [2];
    logic [2:0]  m_op [2];
    logic        m_uns [2], m_one [2], m_ovf [2], m_as [2], m_bs [2];
    logic [47:0] m_acc [2];
    logic [31:0] m_res [2];

    function automatic longint sv(input logic [15:0] x, input logic u);
        return u ? longint'(x) : longint'($signed(x));
    endfunction

    function automatic void m_run(input int b);
        longint p, ac, t;
        logic [2:0] op;
        op = m_op[b];
        p  = sv(m_a[b], m_uns[b]) * sv(m_b[b], m_uns[b]);
        ac = m_uns[b] ? longint'(m_acc[b]) : longint'($signed(m_acc[b]));
        case (op[1:0])
            2'b00: t = p;
            2'b01: t = ac + p;
            2'b10: t = -p;
            default: t = ac - p;
        endcase
        if (op[0]) begin
            if (!op[2]) begin
                if (m_uns[b]) m_ovf[b] = (t < 0) || (t > 64'sh0000_FFFF_FFFF_FFFF);
                else m_ovf[b] = (t < -64'sh0000_8000_0000_0000) || (t > 64'sh0000_7FFF_FFFF_FFFF);
            end
        end
        if (!op[2]) begin
            if (op[0]) begin
                longint r2;
                r2 = op[1] ? ac - 2 * p : ac + 2 * p;
                m_res[b] = r2[31:0];
            end else m_res[b] = t[31:0];
            m_acc[b] = t[47:0];
        end else m_res[b] = t[31:0];
    endfunction

    function automatic void m_write(input int b, input logic [2:0] a, input logic [15:0] d);
        bit go;
        go = (a == 3'd2 && (m_one[b] || m_as[b])) || (a == 3'd1 && !m_one[b] && m_bs[b]);
        case (a)
            3'd0: begin m_op[b] = d[2:0]; m_uns[b] = d[3]; m_one[b] = d[4]; end
            3'd1: begin m_a[b] = d; m_as[b] = 1; end
            3'd2: begin m_b[b] = d; m_bs[b] = 1; end
            3'd3: m_acc[b][15:0] = d;
            3'd4: m_acc[b][31:16] = d;
            3'd5: m_acc[b][47:32] = d;
            default: ;
        endcase
        if (go) begin
            m_run(b);
            m_as[b] = 0;
            m_bs[b] = 0;
        end
    endfunction

    task automatic wr(input int b, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bank_sel = b[0]; wr_en = 1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 0;
        m_write(b, a, d);
    endtask

    task automatic rd(input int b, input logic [2:0] a, output logic [15:0] v);
        bank_sel = b[0]; rd_addr = a;
        #1 v = rdata;
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input string req, input int b, input logic [47:0] exp);
        logic [15:0] v0, v1, v2;
        rd(b, 3'd3, v0); rd(b, 3'd4, v1); rd(b, 3'd5, v2);
        chk(req, {v2, v1, v0}, exp);
    endtask

    task automatic chk_res(input string req, input int b, input logic [31:0] exp);
        logic [15:0] v0, v1;
        rd(b, 3'd6, v0); rd(b, 3'd7, v1);
        chk(req, {16'h0, v1, v0}, {16'h0, exp});
    endtask

    task automatic chk_all(input string req, input int b);
        logic [15:0] c;
        rd(b, 3'd0, c);
        chk(req, {32'h0, c}, {32'h0, 8'h0, m_ovf[b], 2'b0, m_one[b], m_uns[b], m_op[b]});
        chk_acc(req, b, m_acc[b]);
        chk_res(req, b, m_res[b]);
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_res;
        logic [47:0] old_acc;
        logic [15:0] v;
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 2; b++) begin
            m_a[b] = 0; m_b[b] = 0; m_op[b] = 0; m_uns[b] = 0; m_one[b] = 0;
            m_ovf[b] = 0; m_as[b] = 0; m_bs[b] = 0; m_acc[b] = 0; m_res[b] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 8; a++) begin
                rd(b, 3'(a), v);
                chk("R1 reset", {32'h0, v}, 48'h0);
            end

        // R4 R6 R8: signed multiply with write-back, timing
        wr(0, 3'd0, 16'h0000);
        wr(0, 3'd1, 16'hFFFF);
        old_res = m_res[0]; old_acc = m_acc[0];
        wr(0, 3'd2, 16'h0003);
        chk_res("R6 before", 0, old_res);
        @(posedge clk); #1;
        chk_res("R6 next cycle", 0, 32'hFFFF_FFFD);
        chk_acc("R8 old acc", 0, old_acc);
        @(posedge clk); #1;
        chk_acc("R4 R8 new acc", 0, 48'hFFFF_FFFF_FFFD);

        // R7: accumulate with write-back, extra cycle, doubled product
        wr(0, 3'd0, 16'h0001);
        wr(0, 3'd1, 16'h0002);
        old_res = m_res[0];
        wr(0, 3'd2, 16'h0005);
        @(posedge clk); #1;
        chk_res("R7 wait cycle", 0, old_res);
        @(posedge clk); #1;
        chk_res("R7 result", 0, 32'd17);
        chk_acc("R4 acc", 0, 48'd7);

        // R4: negate
        wr(0, 3'd0, 16'h0002);
        wr(0, 3'd1, 16'h0004);
        wr(0, 3'd2, 16'h0003);
        settle();
        chk_all("R4 negate", 0);
        chk_acc("R4 negate acc", 0, 48'hFFFF_FFFF_FFF4);

        // R2: operand A alone starts nothing, then B starts; B then A order
        wr(0, 3'd0, 16'h0000);
        wr(0, 3'd1, 16'h0007);
        settle();
        chk_res("R2 A alone", 0, 32'hFFFF_FFF4);
        wr(0, 3'd2, 16'h0002);
        settle();
        chk_res("R2 pair", 0, 32'd14);
        wr(0, 3'd2, 16'h0003);
        settle();
        chk_res("R2 B alone", 0, 32'd14);
        wr(0, 3'd1, 16'h0005);
        settle();
        chk_res("R2 B then A", 0, 32'd15);
        wr(0, 3'd0, 16'h0010);
        wr(0, 3'd2, 16'h0004);
        settle();
        chk_res("R2 single operand", 0, 32'd20);

        // R3: unsigned carry sets overflow; other codes keep it
        wr(0, 3'd0, 16'h0009);
        wr(0, 3'd3, 16'hFFFF); wr(0, 3'd4, 16'hFFFF); wr(0, 3'd5, 16'hFFFF);
        wr(0, 3'd1, 16'h0001); wr(0, 3'd2, 16'h0001);
        settle();
        rd(0, 3'd0, v);
        chk("R3 unsigned overflow", {47'h0, v[7]}, 48'h1);
        wr(0, 3'd0, 16'h0008);
        wr(0, 3'd1, 16'h0001); wr(0, 3'd2, 16'h0001);
        settle();
        rd(0, 3'd0, v);
        chk("R3 multiply keeps flag", {47'h0, v[7]}, 48'h1);
        wr(0, 3'd0, 16'h000D);
        wr(0, 3'd1, 16'hFFFF); wr(0, 3'd2, 16'hFFFF);
        settle();
        rd(0, 3'd0, v);
        chk("R3 code 101 keeps flag", {47'h0, v[7]}, 48'h1);
        chk_all("R5 no write-back", 0);
        wr(0, 3'd0, 16'h0003);
        wr(0, 3'd3, 16'hFFFF); wr(0, 3'd4, 16'hFFFF); wr(0, 3'd5, 16'h7FFF);
        wr(0, 3'd1, 16'h0001); wr(0, 3'd2, 16'h0001);
        settle();
        rd(0, 3'd0, v);
        chk("R3 signed clear", {47'h0, v[7]}, 48'h0);
        wr(0, 3'd0, 16'h0001);
        wr(0, 3'd1, 16'h0002); wr(0, 3'd2, 16'h0001);
        settle();
        rd(0, 3'd0, v);
        chk("R3 signed overflow", {47'h0, v[7]}, 48'h1);
        chk_all("R3 state", 0);

        // R10: bank 1 activity leaves bank 0 alone
        wr(1, 3'd0, 16'h0001);
        wr(1, 3'd1, 16'h1234); wr(1, 3'd2, 16'h0100);
        settle();
        chk_all("R10 bank1", 1);
        chk_all("R10 bank0 kept", 0);

        // R9: back-to-back starts in single-operand mode
        wr(0, 3'd0, 16'h0011);
        wr(0, 3'd3, 16'h0000); wr(0, 3'd4, 16'h0000); wr(0, 3'd5, 16'h0000);
        wr(0, 3'd1, 16'h0003);
        wr(0, 3'd2, 16'h0002);
        wr(0, 3'd2, 16'h0004);
        wr(0, 3'd2, 16'hFFFF);
        settle();
        chk_all("R9 back-to-back", 0);

        // R4 R5 R10: random
        for (int i = 0; i < 400; i++) begin
            int b;
            logic [2:0] op;
            logic uns, one;
            b   = $urandom_range(0, 1);
            op  = 3'($urandom_range(0, 7));
            uns = (op[1:0] == 2'b10) ? 1'b0 : 1'($urandom_range(0, 1));
            one = 1'($urandom_range(0, 1));
            wr(b, 3'd0, {11'h0, one, uns, op});
            if ($urandom_range(0, 3) == 0) begin
                wr(b, 3'd3, 16'($urandom)); wr(b, 3'd4, 16'($urandom));
                wr(b, 3'd5, 16'($urandom));
            end
            wr(b, 3'd1, 16'($urandom));
            wr(b, 3'd2, 16'($urandom));
            settle();
            chk_all(op[2] ? "R5 random" : "R4 random", b);
            if (i % 50 == 0) chk_all("R10 random other bank", 1 - b);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule